// File: doc/BRIEF.md
# Accumulator ALU with Destination Select

This block is the 8-bit execution datapath of a small accumulator-style controller core. It holds the working register W and three status flags: zero (Z), carry (C) and half carry (DC). On each accepted operation it combines W with one other operand. That operand is either a byte read from the register file or an 8-bit literal. The result is steered either back into W or out to the register-file write port.

Every accepted operation takes one clock. The decoder in front of the block presents an operation code, a destination bit, a register address, the register's current contents, a literal and a bit position, and raises `op_valid`. The updates to W and to the flags happen on the next rising edge, behind that single enable. The register-file write request (`rf_we`, `rf_waddr`, `rf_wdata`) is combinational, so the storage captures it on the same edge. Each operation changes only its own group of flags. Subtraction uses an inverted-borrow convention for C and DC. In the literal form of subtraction, the literal is the minuend.

Top module: `acc_alu_top`

## Requirements
- R1: After reset, W is 0x00 and Z, C and DC are all 0. With no accepted operation, `rf_we` is 0.
- R2: The `op_code` values are as follows. 0 clears W. 1 clears the register. 2 loads the literal into W. 3 stores W to the register. 4 moves the register. 5 swaps nibbles. 6 sets a bit. 7 clears a bit. 8 increments, 9 decrements and 10 complements. 11 adds the literal and 12 adds the register. 13 adds the register with carry. 14 computes literal minus W and 15 register minus W. 16 subtracts with borrow. 17 and 18 are AND with the literal and with the register. 19 and 20 are OR with the literal and with the register. 21 and 22 are XOR with the literal and with the register. For operations 4, 5 and 8 to 22 that take a register operand, `dest_f`=0 sends the result to W and `dest_f`=1 sends it to the register. Operations 1, 3, 6 and 7 always write the register. Operations 0, 2 and the literal forms always write W. A register write raises `rf_we` with `rf_waddr`=`f_addr` and leaves W unchanged. A write to W leaves `rf_we` at 0.
- R3: The add operations produce W+k, W+f, and W+f+C. C takes the carry out of bit 7 and DC takes the carry out of bit 3.
- R4: The subtract operations produce k−W, f−W, and f−W−(NOT C). C=1 means no borrow from bit 8 and DC=1 means no borrow from bit 4.
- R5: For every operation except swap, bit set and bit clear, Z becomes 1 exactly when the 8-bit result is 0x00.
- R6: Increment, decrement, complement, AND, OR and XOR update Z only. C and DC keep their values.
- R7: Swap exchanges the upper and lower nibbles of f. Bit set and bit clear force bit `bit_sel` (0 to 7) of f to 1 or to 0. None of the three changes any flag.
- R8: Load-literal puts k in W. Move copies f to its destination. Store copies W to the register. The two clears write 0x00. All of these update Z only.
- R9: While `op_valid` is 0, or when `op_code` is 23 to 31, W and all flags hold their values and `rf_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept the presented operation this cycle |
| op_code | input | 5 | Operation select (see R2) |
| dest_f | input | 1 | 0: result to W, 1: result to register |
| f_addr | input | 7 | Direct register address |
| f_rdata | input | 8 | Current contents of the addressed register |
| lit | input | 8 | Literal operand |
| bit_sel | input | 3 | Bit position for bit set/clear |
| w_q | output | 8 | Working register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / inverted borrow flag |
| flag_dc | output | 1 | Half carry / inverted nibble borrow flag |
| rf_we | output | 1 | Register-file write request |
| rf_waddr | output | 7 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The hardest states to reach are the carry-chained operations, add-with-carry and subtract-with-borrow. For these, and for the check that flag groups outside an operation are left alone, C and DC must already hold chosen values before the operation under test. The ports offer no direct way to load flags. So before each table entry the bench runs a short preamble: it loads 0xFF into W, then adds either 0 or 1. This leaves C and DC both 0 or both 1. It then loads the test's W value, which changes only Z. As a result, each entry starts from a known W and known flags, and the flags an operation must not touch can be compared against that starting point.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_CLR_W  = 5'd0,
        OP_CLR_F  = 5'd1,
        OP_LD_LIT = 5'd2,
        OP_ST_W   = 5'd3,
        OP_LD_F   = 5'd4,
        OP_SWAP   = 5'd5,
        OP_BSET   = 5'd6,
        OP_BCLR   = 5'd7,
        OP_INC    = 5'd8,
        OP_DEC    = 5'd9,
        OP_NOT    = 5'd10,
        OP_ADD_K  = 5'd11,
        OP_ADD_F  = 5'd12,
        OP_ADDC_F = 5'd13,
        OP_SUB_K  = 5'd14,
        OP_SUB_F  = 5'd15,
        OP_SUBB_F = 5'd16,
        OP_AND_K  = 5'd17,
        OP_AND_F  = 5'd18,
        OP_OR_K   = 5'd19,
        OP_OR_F   = 5'd20,
        OP_XOR_K  = 5'd21,
        OP_XOR_F  = 5'd22
    } op_e;

    typedef enum logic [3:0] {
        LU_ZERO,
        LU_PASS_A,
        LU_PASS_W,
        LU_AND,
        LU_OR,
        LU_XOR,
        LU_INC,
        LU_DEC,
        LU_NOT,
        LU_SWAP,
        LU_BSET,
        LU_BCLR
    } lu_op_e;

    typedef enum logic [1:0] {
        DST_FIELD,
        DST_W,
        DST_F
    } dst_mode_e;

    typedef struct packed {
        logic      legal;
        logic      use_lit;
        logic      arith;
        logic      subtract;
        logic      chain_c;
        lu_op_e    lu_op;
        dst_mode_e dst;
        logic      upd_z;
        logic      upd_cdc;
    } ctrl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl         = '0;
        ctrl.legal   = 1'b1;
        ctrl.lu_op   = LU_PASS_A;
        ctrl.dst     = DST_FIELD;
        ctrl.upd_z   = 1'b1;
        case (op_code)
            OP_CLR_W:  begin ctrl.lu_op = LU_ZERO;   ctrl.dst = DST_W; end
            OP_CLR_F:  begin ctrl.lu_op = LU_ZERO;   ctrl.dst = DST_F; end
            OP_LD_LIT: begin ctrl.use_lit = 1'b1;    ctrl.dst = DST_W; end
            OP_ST_W:   begin ctrl.lu_op = LU_PASS_W; ctrl.dst = DST_F; end
            OP_LD_F:   ;
            OP_SWAP:   begin ctrl.lu_op = LU_SWAP;   ctrl.upd_z = 1'b0; end
            OP_BSET:   begin ctrl.lu_op = LU_BSET;   ctrl.dst = DST_F; ctrl.upd_z = 1'b0; end
            OP_BCLR:   begin ctrl.lu_op = LU_BCLR;   ctrl.dst = DST_F; ctrl.upd_z = 1'b0; end
            OP_INC:    ctrl.lu_op = LU_INC;
            OP_DEC:    ctrl.lu_op = LU_DEC;
            OP_NOT:    ctrl.lu_op = LU_NOT;
            OP_ADD_K:  begin ctrl.arith = 1'b1; ctrl.use_lit = 1'b1; ctrl.dst = DST_W; ctrl.upd_cdc = 1'b1; end
            OP_ADD_F:  begin ctrl.arith = 1'b1; ctrl.upd_cdc = 1'b1; end
            OP_ADDC_F: begin ctrl.arith = 1'b1; ctrl.chain_c = 1'b1; ctrl.upd_cdc = 1'b1; end
            OP_SUB_K:  begin ctrl.arith = 1'b1; ctrl.subtract = 1'b1; ctrl.use_lit = 1'b1;
                             ctrl.dst = DST_W; ctrl.upd_cdc = 1'b1; end
            OP_SUB_F:  begin ctrl.arith = 1'b1; ctrl.subtract = 1'b1; ctrl.upd_cdc = 1'b1; end
            OP_SUBB_F: begin ctrl.arith = 1'b1; ctrl.subtract = 1'b1; ctrl.chain_c = 1'b1;
                             ctrl.upd_cdc = 1'b1; end
            OP_AND_K:  begin ctrl.lu_op = LU_AND; ctrl.use_lit = 1'b1; ctrl.dst = DST_W; end
            OP_AND_F:  ctrl.lu_op = LU_AND;
            OP_OR_K:   begin ctrl.lu_op = LU_OR;  ctrl.use_lit = 1'b1; ctrl.dst = DST_W; end
            OP_OR_F:   ctrl.lu_op = LU_OR;
            OP_XOR_K:  begin ctrl.lu_op = LU_XOR; ctrl.use_lit = 1'b1; ctrl.dst = DST_W; end
            OP_XOR_F:  ctrl.lu_op = LU_XOR;
            default:   ctrl = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              hcarry
);

    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;

    always_comb begin
        full   = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        low    = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        sum    = full[DATA_W-1:0];
        cout   = full[DATA_W];
        hcarry = low[NIB_W];
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  lu_op_e            lu_op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] w,
    input  logic [BIT_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] y
);

    localparam int NIB_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = ONE << bit_sel;
        case (lu_op)
            LU_ZERO:   y = '0;
            LU_PASS_A: y = a;
            LU_PASS_W: y = w;
            LU_AND:    y = a & w;
            LU_OR:     y = a | w;
            LU_XOR:    y = a ^ w;
            LU_INC:    y = a + ONE;
            LU_DEC:    y = a - ONE;
            LU_NOT:    y = ~a;
            LU_SWAP:   y = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
            LU_BSET:   y = a | mask;
            LU_BCLR:   y = a & ~mask;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              dest_f,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [DATA_W-1:0] f_rdata,
    input  logic [DATA_W-1:0] lit,
    input  logic [BIT_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] w_q,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_dc,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    typedef struct packed {
        logic [DATA_W-1:0] w;
        logic              z;
        logic              c;
        logic              dc;
    } state_t;

    state_t state_d, state_q;
    ctrl_t  ctrl;

    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_hc;
    logic [DATA_W-1:0] lu_y;
    logic [DATA_W-1:0] result;
    logic              to_f;
    logic              to_w;
    logic              commit;

    acc_alu_decode u_decode (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    acc_alu_adder #(.DATA_W(DATA_W)) u_adder (
        .x      (opnd_a),
        .y      (add_y),
        .cin    (add_cin),
        .sum    (add_sum),
        .cout   (add_cout),
        .hcarry (add_hc)
    );

    acc_alu_bitops #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_bitops (
        .lu_op   (ctrl.lu_op),
        .a       (opnd_a),
        .w       (state_q.w),
        .bit_sel (bit_sel),
        .y       (lu_y)
    );

    always_comb begin
        opnd_a  = ctrl.use_lit ? lit : f_rdata;
        add_y   = ctrl.subtract ? ~state_q.w : state_q.w;
        add_cin = ctrl.chain_c ? state_q.c : ctrl.subtract;
        result  = ctrl.arith ? add_sum : lu_y;

        commit  = op_valid & ctrl.legal;
        case (ctrl.dst)
            DST_W:   to_f = 1'b0;
            DST_F:   to_f = 1'b1;
            default: to_f = dest_f;
        endcase
        to_w    = commit & ~to_f;

        state_d = state_q;
        if (to_w) begin
            state_d.w = result;
        end
        if (commit && ctrl.upd_z) begin
            state_d.z = (result == '0);
        end
        if (commit && ctrl.upd_cdc) begin
            state_d.c  = add_cout;
            state_d.dc = add_hc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign w_q      = state_q.w;
    assign flag_z   = state_q.z;
    assign flag_c   = state_q.c;
    assign flag_dc  = state_q.dc;
    assign rf_we    = commit & to_f;
    assign rf_waddr = f_addr;
    assign rf_wdata = result;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] w_q,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_dc,
    input logic              rf_we
);

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(w_q) && $stable(flag_z) && $stable(flag_c) && $stable(flag_dc))); // R9

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !rf_we); // R9

    AST_RF_WRITE_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> $stable(w_q)); // R2

    AST_BITOPS_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {OP_SWAP, OP_BSET, OP_BCLR}))
        |=> ($stable(flag_z) && $stable(flag_c) && $stable(flag_dc))); // R7

    AST_ZONLY_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {OP_INC, OP_DEC, OP_NOT, OP_AND_K, OP_AND_F,
                                      OP_OR_K, OP_OR_F, OP_XOR_K, OP_XOR_F}))
        |=> ($stable(flag_c) && $stable(flag_dc))); // R6

    AST_LOAD_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LD_LIT) |=> (flag_z == (w_q == '0))); // R5

    AST_CLEAR_W: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLR_W) |=> (w_q == '0 && flag_z)); // R8

endmodule

bind acc_alu_top acc_alu_checker #(.DATA_W(DATA_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .w_q      (w_q),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_dc  (flag_dc),
    .rf_we    (rf_we)
);

// File: tb/acc_alu_tb.sv
module acc_alu_top_tb_top;
    import acc_alu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 29;

    typedef struct packed {
        logic [7:0] w0;
        logic       c0;
        logic [4:0] op;
        logic       dst;
        logic [7:0] f;
        logic [7:0] k;
        logic [2:0] bp;
        logic [7:0] ew;
        logic       ez;
        logic       ec;
        logic       edc;
        logic       ewe;
        logic [7:0] ewd;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h3A, 1'b0, OP_ADD_K,  1'b0, 8'h00, 8'h47, 3'd0, 8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{8'hF0, 1'b0, OP_ADD_F,  1'b0, 8'h20, 8'h00, 3'd0, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        '{8'h80, 1'b1, OP_ADD_F,  1'b1, 8'h80, 8'h00, 3'd0, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00},
        '{8'h0F, 1'b1, OP_ADDC_F, 1'b0, 8'h00, 8'h00, 3'd0, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{8'h05, 1'b0, OP_SUB_K,  1'b0, 8'h00, 8'h1A, 3'd0, 8'h15, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h1A, 1'b1, OP_SUB_K,  1'b0, 8'h00, 8'h1A, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h30, 1'b1, OP_SUB_F,  1'b0, 8'h20, 8'h00, 3'd0, 8'hF0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{8'h01, 1'b0, OP_SUB_F,  1'b1, 8'h10, 8'h00, 3'd0, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F},
        '{8'h05, 1'b0, OP_SUBB_F, 1'b0, 8'h05, 8'h00, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{8'h05, 1'b1, OP_SUBB_F, 1'b0, 8'h07, 8'h00, 3'd0, 8'h02, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h33, 1'b1, OP_INC,    1'b0, 8'hFF, 8'h00, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h00, 1'b0, OP_DEC,    1'b1, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
        '{8'h12, 1'b1, OP_NOT,    1'b0, 8'hFF, 8'h00, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'hF0, 1'b0, OP_AND_K,  1'b0, 8'h00, 8'h0F, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{8'h78, 1'b1, OP_AND_F,  1'b1, 8'h0F, 8'h00, 3'd0, 8'h78, 1'b0, 1'b1, 1'b1, 1'b1, 8'h08},
        '{8'h00, 1'b0, OP_OR_K,   1'b0, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{8'hF0, 1'b0, OP_OR_F,   1'b0, 8'h0F, 8'h00, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{8'hF0, 1'b1, OP_XOR_K,  1'b0, 8'h00, 8'hFF, 3'd0, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h5A, 1'b0, OP_XOR_F,  1'b1, 8'h5A, 8'h00, 3'd0, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00},
        '{8'h00, 1'b1, OP_SWAP,   1'b0, 8'hA5, 8'h00, 3'd0, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h11, 1'b0, OP_SWAP,   1'b1, 8'h3C, 8'h00, 3'd0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3},
        '{8'h00, 1'b0, OP_BSET,   1'b0, 8'h00, 8'h00, 3'd7, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80},
        '{8'h01, 1'b1, OP_BCLR,   1'b1, 8'hFF, 8'h00, 3'd3, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF7},
        '{8'h44, 1'b0, OP_LD_F,   1'b0, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{8'h00, 1'b1, OP_LD_F,   1'b1, 8'h9C, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h9C},
        '{8'h6E, 1'b0, OP_ST_W,   1'b0, 8'h00, 8'h00, 3'd0, 8'h6E, 1'b0, 1'b0, 1'b0, 1'b1, 8'h6E},
        '{8'h21, 1'b0, OP_CLR_F,  1'b0, 8'h55, 8'h00, 3'd0, 8'h21, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00},
        '{8'h21, 1'b1, OP_CLR_W,  1'b1, 8'h55, 8'h00, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{8'h21, 1'b1, OP_LD_LIT, 1'b1, 8'h55, 8'h00, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic       dest_f = 1'b0;
    logic [6:0] f_addr = '0;
    logic [7:0] f_rdata = '0;
    logic [7:0] lit = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] w_q;
    logic       flag_z, flag_c, flag_dc, rf_we;
    logic [6:0] rf_waddr;
    logic [7:0] rf_wdata;

    logic       cap_we;
    logic [6:0] cap_addr;
    logic [7:0] cap_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_alu_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .dest_f   (dest_f),
        .f_addr   (f_addr),
        .f_rdata  (f_rdata),
        .lit      (lit),
        .bit_sel  (bit_sel),
        .w_q      (w_q),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .flag_dc  (flag_dc),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [4:0] op);
        if (op inside {OP_ADD_K, OP_ADD_F, OP_ADDC_F}) return "R3";
        if (op inside {OP_SUB_K, OP_SUB_F, OP_SUBB_F}) return "R4";
        if (op inside {OP_SWAP, OP_BSET, OP_BCLR}) return "R7";
        if (op inside {OP_CLR_W, OP_CLR_F, OP_LD_LIT, OP_ST_W, OP_LD_F}) return "R8";
        return "R6";
    endfunction

    // Called at a falling edge; returns at the next falling edge with valid low.
    task automatic do_op(input logic [4:0] op, input logic d, input logic [7:0] f,
                         input logic [7:0] k, input logic [2:0] b, input logic [6:0] a);
        op_code  = op;
        dest_f   = d;
        f_rdata  = f;
        lit      = k;
        bit_sel  = b;
        f_addr   = a;
        op_valid = 1'b1;
        #1;
        cap_we   = rf_we;
        cap_addr = rf_waddr;
        cap_data = rf_wdata;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "w after reset", w_q, 8'h00);
        check("R1", "flags after reset", {5'b0, flag_z, flag_c, flag_dc}, 8'h00);
        check("R1", "rf_we after reset", {7'b0, rf_we}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v  = VECS[i];
            rq = req_of(v.op);
            do_op(OP_LD_LIT, 1'b0, 8'h00, 8'hFF, 3'd0, 7'h00);
            do_op(OP_ADD_K, 1'b0, 8'h00, {7'b0, v.c0}, 3'd0, 7'h00);
            do_op(OP_LD_LIT, 1'b0, 8'h00, v.w0, 3'd0, 7'h00);
            do_op(v.op, v.dst, v.f, v.k, v.bp, 7'(7'h40 + i));
            check(rq, $sformatf("vec %0d w", i), w_q, v.ew);
            check("R5", $sformatf("vec %0d z", i), {7'b0, flag_z}, {7'b0, v.ez});
            check(rq, $sformatf("vec %0d c", i), {7'b0, flag_c}, {7'b0, v.ec});
            check(rq, $sformatf("vec %0d dc", i), {7'b0, flag_dc}, {7'b0, v.edc});
            check("R2", $sformatf("vec %0d rf_we", i), {7'b0, cap_we}, {7'b0, v.ewe});
            if (v.ewe) begin
                check(rq, $sformatf("vec %0d rf_wdata", i), cap_data, v.ewd);
                check("R2", $sformatf("vec %0d rf_waddr", i), {1'b0, cap_addr}, {1'b0, 7'(7'h40 + i)});
            end
        end

        // R7: every bit position for set and clear
        for (int b = 0; b < 8; b++) begin
            do_op(OP_BSET, 1'b0, 8'h00, 8'h00, 3'(b), 7'h11);
            check("R7", $sformatf("bset bit %0d", b), cap_data, 8'(1 << b));
            do_op(OP_BCLR, 1'b1, 8'hFF, 8'h00, 3'(b), 7'h11);
            check("R7", $sformatf("bclr bit %0d", b), cap_data, ~8'(1 << b));
        end

        // R9: operation presented without op_valid is ignored
        do_op(OP_LD_LIT, 1'b0, 8'h00, 8'hFF, 3'd0, 7'h00);
        do_op(OP_ADD_K, 1'b0, 8'h00, 8'h01, 3'd0, 7'h00);
        do_op(OP_LD_LIT, 1'b0, 8'h00, 8'h5A, 3'd0, 7'h00);
        op_code = OP_CLR_F;
        dest_f  = 1'b1;
        #1;
        check("R9", "rf_we while idle", {7'b0, rf_we}, 8'h00);
        op_code = OP_CLR_W;
        repeat (2) @(negedge clk);
        check("R9", "w while idle", w_q, 8'h5A);
        check("R9", "flags while idle", {5'b0, flag_z, flag_c, flag_dc}, 8'h03);

        // R9: unlisted op codes have no effect
        for (int u = 23; u < 32; u++) begin
            do_op(5'(u), 1'b1, 8'h00, 8'h00, 3'd0, 7'h22);
            check("R9", $sformatf("code %0d rf_we", u), {7'b0, cap_we}, 8'h00);
            check("R9", $sformatf("code %0d w", u), w_q, 8'h5A);
            check("R9", $sformatf("code %0d flags", u), {5'b0, flag_z, flag_c, flag_dc}, 8'h03);
        end

        // R1: reset mid-run returns to the reset state
        rst_n = 1'b0;
        #1;
        check("R1", "w on reset", w_q, 8'h00);
        check("R1", "flags on reset", {5'b0, flag_z, flag_c, flag_dc}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule